// File: doc/BRIEF.md
# Register Rename and Allocation Unit

This block sits between decode and scheduling and renames one micro-operation per cycle. An op arrives with a destination flag, a destination architectural register and two source architectural registers. The unit returns the physical registers that currently hold the sources, a reorder slot index and, when the op writes a register, a newly allocated physical register together with the mapping it replaces. Reorder slots and physical registers come from two separate pools. A circular slot buffer tracks which ops have completed. A bitmap holds the free physical registers.

Two alias tables hold the register mappings. The speculative table is updated as each op is renamed. The committed table changes only when an op retires. The oldest op retires once it is done. Retirement changes only mappings and moves no data: the committed table takes the new physical register and the register that was displaced goes back to the pool. A flush drops every op in flight within one cycle. It copies the committed table over the speculative one and rebuilds the free pool from the registers that the committed table does not use.

Top module: `rename_unit`

## Requirements
- R1: Out of reset, `in_ready` is high, the reorder buffer is empty, architectural register k maps to physical register k, and physical registers NUM_ARCH and above are free.
- R2: Accepted ops (`in_valid && in_ready`) receive reorder slot indices in strict sequence, starting at 0 and wrapping from ROB_DEPTH-1 to 0.
- R3: In the cycle an op is accepted, `out_src_a_phys`/`out_src_b_phys` give the speculative mapping of its sources, including a destination written by any earlier accepted op. An op with `in_has_dst=1` is given the lowest-numbered free physical register on `out_dst_phys`, and the mapping it displaces appears on `out_old_phys`.
- R4: An op with `in_has_dst=0` takes a reorder slot but no physical register, and it leaves the speculative mapping of `in_dst_arch` unchanged.
- R5: `in_ready` is low while the reorder buffer holds ROB_DEPTH ops.
- R6: `in_ready` is low while no physical register is free, even when reorder slots remain.
- R7: `cmp_valid` marks slot `cmp_rob_idx` done. The oldest op retires (`ret_valid` high for one cycle, showing its destination flag, architectural register, new and displaced physical registers) in the cycle after it is both oldest and done, one op per cycle, in allocation order.
- R8: When an op with a destination retires, its displaced physical register returns to the free pool and can be allocated from the next cycle on.
- R9: With `flush` high, nothing is accepted or retired. From the next cycle the reorder buffer is empty with the next index 0, sources read the committed mappings, and the free pool holds exactly the registers the committed table does not map.
- R10: A completion report for a slot that holds no op has no effect: an op later placed in that slot does not retire until its own completion arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An op is offered for renaming |
| in_ready | output | 1 | The unit can accept an op this cycle |
| in_has_dst | input | 1 | The offered op writes a register |
| in_dst_arch | input | 3 | Destination architectural register |
| in_src_a_arch | input | 3 | First source architectural register |
| in_src_b_arch | input | 3 | Second source architectural register |
| out_rob_idx | output | 4 | Reorder slot given to the accepted op |
| out_src_a_phys | output | 5 | Physical register of the first source |
| out_src_b_phys | output | 5 | Physical register of the second source |
| out_dst_phys | output | 5 | Newly allocated destination register (0 when no destination) |
| out_old_phys | output | 5 | Mapping displaced by the destination (0 when no destination) |
| cmp_valid | input | 1 | Completion report is valid |
| cmp_rob_idx | input | 4 | Slot that completed |
| flush | input | 1 | Discard all ops in flight and restore committed mappings |
| ret_valid | output | 1 | The oldest op retires this cycle |
| ret_has_dst | output | 1 | The retiring op has a destination |
| ret_arch | output | 3 | Architectural destination of the retiring op |
| ret_new_phys | output | 5 | Physical register committed for that destination |
| ret_old_phys | output | 5 | Physical register released to the free pool |

## Verification
The rename results are combinational and belong to the cycle in which the op is offered. The bench therefore drives each op just after a falling edge and samples the outputs 2 ns later, before the rising edge that commits it. A completion report takes effect at the next rising edge, so the matching retirement is expected one sampled cycle later. A register freed at retirement, and the state restored by a flush, become visible in the cycle after that edge. The bench's reference model applies each effect only at the edge that closes its sampled cycle, so every comparison falls in the cycle in which the result is due.

// File: rtl/rename_pkg.sv
package rename_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/rename_free_list.sv
module rename_free_list #(
    parameter  int unsigned NUM_ARCH = 8,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_en,
    output logic [PHYS_W-1:0]   alloc_idx,
    output logic                any_free,
    input  logic                rel_en,
    input  logic [PHYS_W-1:0]   rel_idx,
    input  logic                flush,
    input  logic [NUM_PHYS-1:0] mapped_mask
);

    logic [NUM_PHYS-1:0] free_q;
    logic [NUM_PHYS-1:0] free_d;

    // lowest-numbered free register wins
    always_comb begin
        alloc_idx = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_q[i]) alloc_idx = PHYS_W'(i);
        end
    end

    assign any_free = |free_q;

    always_comb begin
        free_d = free_q;
        if (alloc_en) free_d[alloc_idx] = 1'b0;
        if (rel_en)   free_d[rel_idx]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                free_q[i] <= (i >= int'(NUM_ARCH));
            end
        end else if (flush) begin
            free_q <= ~mapped_mask;
        end else begin
            free_q <= free_d;
        end
    end

endmodule

// File: rtl/rename_alias_tables.sv
module rename_alias_tables #(
    parameter  int unsigned NUM_ARCH = 8,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned ARCH_W   = $clog2(NUM_ARCH),
    localparam int unsigned PHYS_W   = $clog2(NUM_PHYS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ARCH_W-1:0]   rd_a_arch,
    input  logic [ARCH_W-1:0]   rd_b_arch,
    input  logic [ARCH_W-1:0]   rd_dst_arch,
    output logic [PHYS_W-1:0]   rd_a_phys,
    output logic [PHYS_W-1:0]   rd_b_phys,
    output logic [PHYS_W-1:0]   rd_dst_phys,
    input  logic                spec_wr_en,
    input  logic [ARCH_W-1:0]   spec_wr_arch,
    input  logic [PHYS_W-1:0]   spec_wr_phys,
    input  logic                commit_en,
    input  logic [ARCH_W-1:0]   commit_arch,
    input  logic [PHYS_W-1:0]   commit_phys,
    input  logic                flush,
    output logic [NUM_PHYS-1:0] mapped_mask
);

    logic [PHYS_W-1:0] spec_q [NUM_ARCH];
    logic [PHYS_W-1:0] cmt_q  [NUM_ARCH];

    assign rd_a_phys   = spec_q[rd_a_arch];
    assign rd_b_phys   = spec_q[rd_b_arch];
    assign rd_dst_phys = spec_q[rd_dst_arch];

    always_comb begin
        mapped_mask = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            mapped_mask[cmt_q[i]] = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_ARCH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    spec_q[g] <= PHYS_W'(g);
                end else if (flush) begin
                    spec_q[g] <= cmt_q[g];
                end else if (spec_wr_en && spec_wr_arch == ARCH_W'(g)) begin
                    spec_q[g] <= spec_wr_phys;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    cmt_q[g] <= PHYS_W'(g);
                end else if (commit_en && commit_arch == ARCH_W'(g)) begin
                    cmt_q[g] <= commit_phys;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rename_rob.sv
module rename_rob
    import rename_pkg::*;
#(
    parameter  int unsigned DEPTH  = 16,
    parameter  int unsigned ARCH_W = 3,
    parameter  int unsigned PHYS_W = 5,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push_en,
    input  logic              push_has_dst,
    input  logic [ARCH_W-1:0] push_arch,
    input  logic [PHYS_W-1:0] push_new_phys,
    input  logic [PHYS_W-1:0] push_old_phys,
    output logic [IDX_W-1:0]  tail_idx,
    output logic              full,
    input  logic              cmp_en,
    input  logic [IDX_W-1:0]  cmp_idx,
    input  logic              pop_en,
    output logic              head_done,
    output logic              head_has_dst,
    output logic [ARCH_W-1:0] head_arch,
    output logic [PHYS_W-1:0] head_new_phys,
    output logic [PHYS_W-1:0] head_old_phys
);

    typedef struct packed {
        logic              has_dst;
        logic [ARCH_W-1:0] arch;
        logic [PHYS_W-1:0] new_phys;
        logic [PHYS_W-1:0] old_phys;
    } rob_entry_t;

    slot_state_e       state_q [DEPTH];
    rob_entry_t        entry_q [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [IDX_W-1:0]  tail_q;
    logic [CNT_W-1:0]  count_q;
    logic [IDX_W-1:0]  head_nxt;
    logic [IDX_W-1:0]  tail_nxt;
    rob_entry_t        push_entry;
    rob_entry_t        head_entry;

    assign head_nxt = IDX_W'(wrap_inc(int'(head_q), DEPTH));
    assign tail_nxt = IDX_W'(wrap_inc(int'(tail_q), DEPTH));

    assign push_entry = '{has_dst: push_has_dst, arch: push_arch,
                          new_phys: push_new_phys, old_phys: push_old_phys};
    assign head_entry = entry_q[head_q];

    assign tail_idx      = tail_q;
    assign full          = (count_q == CNT_W'(DEPTH));
    assign head_done     = (state_q[head_q] == SLOT_DONE);
    assign head_has_dst  = head_entry.has_dst;
    assign head_arch     = head_entry.arch;
    assign head_new_phys = head_entry.new_phys;
    assign head_old_phys = head_entry.old_phys;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) state_q[i] <= SLOT_FREE;
        end else begin
            if (cmp_en && state_q[cmp_idx] == SLOT_WAIT) begin
                state_q[cmp_idx] <= SLOT_DONE;
            end
            if (pop_en) begin
                state_q[head_q] <= SLOT_FREE;
                head_q          <= head_nxt;
            end
            if (push_en) begin
                state_q[tail_q] <= SLOT_WAIT;
                tail_q          <= tail_nxt;
            end
            case ({push_en, pop_en})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) entry_q[tail_q] <= push_entry;
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter  int unsigned NUM_ARCH  = 8,
    parameter  int unsigned NUM_PHYS  = 32,
    parameter  int unsigned ROB_DEPTH = 16,
    localparam int unsigned ARCH_W    = $clog2(NUM_ARCH),
    localparam int unsigned PHYS_W    = $clog2(NUM_PHYS),
    localparam int unsigned ROB_W     = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_has_dst,
    input  logic [ARCH_W-1:0] in_dst_arch,
    input  logic [ARCH_W-1:0] in_src_a_arch,
    input  logic [ARCH_W-1:0] in_src_b_arch,
    output logic [ROB_W-1:0]  out_rob_idx,
    output logic [PHYS_W-1:0] out_src_a_phys,
    output logic [PHYS_W-1:0] out_src_b_phys,
    output logic [PHYS_W-1:0] out_dst_phys,
    output logic [PHYS_W-1:0] out_old_phys,
    input  logic              cmp_valid,
    input  logic [ROB_W-1:0]  cmp_rob_idx,
    input  logic              flush,
    output logic              ret_valid,
    output logic              ret_has_dst,
    output logic [ARCH_W-1:0] ret_arch,
    output logic [PHYS_W-1:0] ret_new_phys,
    output logic [PHYS_W-1:0] ret_old_phys
);

    logic                accept;
    logic                alloc_en;
    logic                retire;
    logic                rob_full;
    logic                any_free;
    logic [PHYS_W-1:0]   alloc_idx;
    logic [PHYS_W-1:0]   prev_map;
    logic [NUM_PHYS-1:0] mapped_mask;
    logic                head_done;

    assign in_ready = !rob_full && any_free && !flush;
    assign accept   = in_valid && in_ready;
    assign alloc_en = accept && in_has_dst;
    assign retire   = head_done && !flush;

    assign out_dst_phys = in_has_dst ? alloc_idx : '0;
    assign out_old_phys = in_has_dst ? prev_map  : '0;
    assign ret_valid    = retire;

    rename_free_list #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_free (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (alloc_en),
        .alloc_idx   (alloc_idx),
        .any_free    (any_free),
        .rel_en      (retire && ret_has_dst),
        .rel_idx     (ret_old_phys),
        .flush       (flush),
        .mapped_mask (mapped_mask)
    );

    rename_alias_tables #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_tables (
        .clk          (clk),
        .rst          (rst),
        .rd_a_arch    (in_src_a_arch),
        .rd_b_arch    (in_src_b_arch),
        .rd_dst_arch  (in_dst_arch),
        .rd_a_phys    (out_src_a_phys),
        .rd_b_phys    (out_src_b_phys),
        .rd_dst_phys  (prev_map),
        .spec_wr_en   (alloc_en),
        .spec_wr_arch (in_dst_arch),
        .spec_wr_phys (alloc_idx),
        .commit_en    (retire && ret_has_dst),
        .commit_arch  (ret_arch),
        .commit_phys  (ret_new_phys),
        .flush        (flush),
        .mapped_mask  (mapped_mask)
    );

    rename_rob #(
        .DEPTH  (ROB_DEPTH),
        .ARCH_W (ARCH_W),
        .PHYS_W (PHYS_W)
    ) u_rob (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .push_en       (accept),
        .push_has_dst  (in_has_dst),
        .push_arch     (in_dst_arch),
        .push_new_phys (out_dst_phys),
        .push_old_phys (out_old_phys),
        .tail_idx      (out_rob_idx),
        .full          (rob_full),
        .cmp_en        (cmp_valid),
        .cmp_idx       (cmp_rob_idx),
        .pop_en        (retire),
        .head_done     (head_done),
        .head_has_dst  (ret_has_dst),
        .head_arch     (ret_arch),
        .head_new_phys (ret_new_phys),
        .head_old_phys (ret_old_phys)
    );

endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
    parameter  int unsigned NUM_PHYS  = 32,
    parameter  int unsigned ROB_DEPTH = 16,
    localparam int unsigned PHYS_W    = $clog2(NUM_PHYS),
    localparam int unsigned ROB_W     = $clog2(ROB_DEPTH),
    localparam int unsigned OCC_W     = $clog2(ROB_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ROB_W-1:0]  out_rob_idx,
    input logic              cmp_valid,
    input logic [ROB_W-1:0]  cmp_rob_idx,
    input logic              flush,
    input logic              ret_valid,
    input logic              ret_has_dst,
    input logic [PHYS_W-1:0] ret_new_phys,
    input logic [PHYS_W-1:0] ret_old_phys
);

    logic                 fire;
    logic [OCC_W-1:0]     occ;
    logic [ROB_W-1:0]     ck_head;
    logic [ROB_W-1:0]     ck_tail;
    logic [ROB_DEPTH-1:0] pend;
    logic [ROB_DEPTH-1:0] done;

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            occ     <= '0;
            ck_head <= '0;
            ck_tail <= '0;
            pend    <= '0;
            done    <= '0;
        end else begin
            if (cmp_valid && pend[cmp_rob_idx]) done[cmp_rob_idx] <= 1'b1;
            if (ret_valid) begin
                pend[ck_head] <= 1'b0;
                done[ck_head] <= 1'b0;
                ck_head <= (ck_head == ROB_W'(ROB_DEPTH - 1)) ? '0 : ck_head + ROB_W'(1);
            end
            if (fire) begin
                pend[ck_tail] <= 1'b1;
                ck_tail <= (ck_tail == ROB_W'(ROB_DEPTH - 1)) ? '0 : ck_tail + ROB_W'(1);
            end
            occ <= occ + OCC_W'(fire) - OCC_W'(ret_valid);
        end
    end

    p_ready_out_of_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> in_ready);

    p_index_order_r2: assert property (@(posedge clk) disable iff (rst)
        fire |-> out_rob_idx == ck_tail);

    p_stall_full_r5: assert property (@(posedge clk) disable iff (rst)
        occ == OCC_W'(ROB_DEPTH) |-> !in_ready);

    p_retire_done_r7: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> (done[ck_head] && occ != '0));

    p_release_differs_r8: assert property (@(posedge clk) disable iff (rst)
        ret_valid && ret_has_dst |-> ret_new_phys != ret_old_phys);

    p_ready_after_flush_r9: assert property (@(posedge clk) disable iff (rst)
        $past(flush) && !flush |-> in_ready);

endmodule

bind rename_unit rename_unit_chk #(
    .NUM_PHYS  (NUM_PHYS),
    .ROB_DEPTH (ROB_DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_rob_idx  (out_rob_idx),
    .cmp_valid    (cmp_valid),
    .cmp_rob_idx  (cmp_rob_idx),
    .flush        (flush),
    .ret_valid    (ret_valid),
    .ret_has_dst  (ret_has_dst),
    .ret_new_phys (ret_new_phys),
    .ret_old_phys (ret_old_phys)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4ns clk = ~clk;

    logic       in_valid = 0, in_has_dst = 0, cmp_valid = 0, flush = 0;
    logic [2:0] in_dst_arch = 0, in_src_a_arch = 0, in_src_b_arch = 0;
    logic [3:0] cmp_rob_idx = 0;
    logic       in_ready, ret_valid, ret_has_dst;
    logic [3:0] out_rob_idx;
    logic [4:0] out_src_a_phys, out_src_b_phys, out_dst_phys, out_old_phys;
    logic [2:0] ret_arch;
    logic [4:0] ret_new_phys, ret_old_phys;

    rename_unit u_rename_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_has_dst(in_has_dst), .in_dst_arch(in_dst_arch),
        .in_src_a_arch(in_src_a_arch), .in_src_b_arch(in_src_b_arch),
        .out_rob_idx(out_rob_idx), .out_src_a_phys(out_src_a_phys),
        .out_src_b_phys(out_src_b_phys), .out_dst_phys(out_dst_phys),
        .out_old_phys(out_old_phys), .cmp_valid(cmp_valid), .cmp_rob_idx(cmp_rob_idx),
        .flush(flush), .ret_valid(ret_valid), .ret_has_dst(ret_has_dst),
        .ret_arch(ret_arch), .ret_new_phys(ret_new_phys), .ret_old_phys(ret_old_phys)
    );

    // second instance with a small register pool so the free list can run dry
    logic       s_valid = 0, s_has_dst = 0, s_cmp = 0;
    logic [2:0] s_dst = 0;
    logic [3:0] s_cmp_idx = 0;
    logic       s_ready, s_ret;
    logic [3:0] s_idx, s_srca, s_srcb, s_dphys, s_ophys, s_rnew, s_rold;
    logic       s_rhd;
    logic [2:0] s_rarch;

    rename_unit #(.NUM_PHYS(12)) u_rename_unit_small (
        .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready),
        .in_has_dst(s_has_dst), .in_dst_arch(s_dst),
        .in_src_a_arch(3'd0), .in_src_b_arch(3'd0),
        .out_rob_idx(s_idx), .out_src_a_phys(s_srca), .out_src_b_phys(s_srcb),
        .out_dst_phys(s_dphys), .out_old_phys(s_ophys), .cmp_valid(s_cmp),
        .cmp_rob_idx(s_cmp_idx), .flush(1'b0), .ret_valid(s_ret),
        .ret_has_dst(s_rhd), .ret_arch(s_rarch), .ret_new_phys(s_rnew),
        .ret_old_phys(s_rold)
    );

    int n_checks = 0;
    int n_fails  = 0;

    // reference model, built from the requirements
    int m_srat [8];
    int m_crat [8];
    bit m_free [32];
    int m_st   [16];   // 0 empty, 1 waiting, 2 done
    bit m_hd   [16];
    int m_arch [16];
    int m_new  [16];
    int m_old  [16];
    int m_head, m_tail, m_cnt;

    // last sampled outputs
    int r_ready, r_idx, r_srca, r_srcb, r_dst, r_old, r_ret, r_rarch, r_rnew, r_rold;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < 32; i++) if (m_free[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_srat[i] = i; m_crat[i] = i; end
        for (int i = 0; i < 32; i++) m_free[i] = (i >= 8);
        for (int i = 0; i < 16; i++) m_st[i] = 0;
        m_head = 0; m_tail = 0; m_cnt = 0;
    endtask

    task automatic step(input bit v, input bit hd, input int d, input int a, input int b,
                        input bit cv, input int ci, input bit fl);
        int  lf;
        bit  exp_ready, exp_ret;
        @(negedge clk);
        in_valid = v; in_has_dst = hd; in_dst_arch = 3'(d);
        in_src_a_arch = 3'(a); in_src_b_arch = 3'(b);
        cmp_valid = cv; cmp_rob_idx = 4'(ci); flush = fl;
        #2ns;
        r_ready = int'(in_ready); r_idx = int'(out_rob_idx);
        r_srca = int'(out_src_a_phys); r_srcb = int'(out_src_b_phys);
        r_dst = int'(out_dst_phys); r_old = int'(out_old_phys);
        r_ret = int'(ret_valid); r_rarch = int'(ret_arch);
        r_rnew = int'(ret_new_phys); r_rold = int'(ret_old_phys);

        lf = low_free();
        exp_ready = (m_cnt < 16) && (lf >= 0) && !fl;
        exp_ret   = !fl && (m_st[m_head] == 2);
        chk("R5 R6 in_ready", r_ready, int'(exp_ready));
        if (v && exp_ready) begin
            chk("R2 rob index", r_idx, m_tail);
            chk("R3 source a", r_srca, m_srat[a]);
            chk("R3 source b", r_srcb, m_srat[b]);
            if (hd) begin
                chk("R3 new dst", r_dst, lf);
                chk("R3 old dst", r_old, m_srat[d]);
            end
        end
        chk("R7 ret_valid", r_ret, int'(exp_ret));
        if (exp_ret) begin
            chk("R7 ret_has_dst", int'(ret_has_dst), int'(m_hd[m_head]));
            if (m_hd[m_head]) begin
                chk("R7 ret_arch", r_rarch, m_arch[m_head]);
                chk("R7 ret_new", r_rnew, m_new[m_head]);
                chk("R8 ret_old", r_rold, m_old[m_head]);
            end
        end

        // effects of the coming edge
        if (fl) begin
            for (int i = 0; i < 16; i++) m_st[i] = 0;
            m_head = 0; m_tail = 0; m_cnt = 0;
            for (int i = 0; i < 32; i++) m_free[i] = 1;
            for (int i = 0; i < 8; i++) begin m_srat[i] = m_crat[i]; m_free[m_crat[i]] = 0; end
        end else begin
            if (cv && m_st[ci] == 1) m_st[ci] = 2;
            if (exp_ret) begin
                if (m_hd[m_head]) begin
                    m_crat[m_arch[m_head]] = m_new[m_head];
                    m_free[m_old[m_head]] = 1;
                end
                m_st[m_head] = 0;
                m_head = (m_head + 1) % 16; m_cnt--;
            end
            if (v && exp_ready) begin
                m_st[m_tail] = 1; m_hd[m_tail] = hd;
                if (hd) begin
                    m_arch[m_tail] = d; m_new[m_tail] = lf; m_old[m_tail] = m_srat[d];
                    m_srat[d] = lf; m_free[lf] = 0;
                end
                m_tail = (m_tail + 1) % 16; m_cnt++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic s_step(input bit v, input bit hd, input int d, input bit cv, input int ci);
        @(negedge clk);
        s_valid = v; s_has_dst = hd; s_dst = 3'(d); s_cmp = cv; s_cmp_idx = 4'(ci);
        #2ns;
    endtask

    initial begin
        #(8ns * 100000);
        n_fails++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_ed42));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2ns;
        chk("R1 ready after reset", int'(in_ready), 1);
        chk("R1 small ready after reset", int'(s_ready), 1);

        // directed renaming sequence
        step(1, 1, 1, 1, 2, 0, 0, 0);            // slot0: arch1 -> p8
        chk("R1 identity source", r_srcb, 2);
        chk("R1 first free register", r_dst, 8);
        step(1, 1, 2, 1, 2, 0, 0, 0);            // slot1: arch2 -> p9
        chk("R3 forwarded source", r_srca, 8);
        step(1, 0, 3, 3, 0, 0, 0, 0);            // slot2: no destination
        chk("R4 no-dst slot", r_idx, 2);
        step(1, 1, 4, 3, 3, 0, 0, 0);            // slot3: arch4 -> p10
        chk("R4 register not consumed", r_dst, 10);
        chk("R4 mapping untouched", r_srca, 3);
        step(0, 0, 0, 0, 0, 1, 1, 0);            // complete slot1 first
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 younger done, older pending", r_ret, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);            // complete slot0
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 oldest retires", r_ret, 1);
        chk("R7 retire new phys", r_rnew, 8);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 next in order", r_rarch, 2);
        step(1, 1, 5, 0, 0, 1, 5, 0);            // slot4 arch5; completion to empty slot5
        chk("R8 released register reused", r_dst, 1);
        step(1, 1, 6, 0, 0, 0, 0, 0);            // slot5 arch6
        step(0, 0, 0, 0, 0, 1, 2, 0);
        step(0, 0, 0, 0, 0, 1, 3, 0);
        step(0, 0, 0, 0, 0, 1, 4, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 stale completion ignored", r_ret, 0);
        step(1, 1, 7, 0, 0, 0, 0, 0);            // slot6 arch7
        step(1, 1, 0, 0, 0, 0, 0, 1);            // flush drops slot5/slot6
        chk("R9 nothing accepted in flush", r_ready, 0);
        step(1, 1, 0, 6, 7, 0, 0, 0);
        chk("R9 index restarts", r_idx, 0);
        chk("R9 committed source", r_srca, 6);
        chk("R9 rebuilt free pool", r_dst, 2);

        // fill the reorder buffer
        for (int i = 0; i < 15; i++) step(1, (i % 2), i % 8, i % 8, 0, 0, 0, 0);
        step(1, 1, 1, 1, 1, 0, 0, 0);
        chk("R5 full buffer stalls", r_ready, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        idle(1);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int ci;
            ci = (m_cnt > 0 && ($urandom % 4) != 0) ? (m_head + int'($urandom % m_cnt)) % 16
                                                      : int'($urandom % 16);
            step(($urandom % 4) != 0, ($urandom % 5) != 0, int'($urandom % 8),
                 int'($urandom % 8), int'($urandom % 8), ($urandom % 3) != 0, ci,
                 ($urandom % 97) == 0);
        end

        // free list exhaustion on the small instance (4 spare registers)
        for (int i = 0; i < 4; i++) begin
            s_step(1, 1, i, 0, 0);
            chk("R6 small accept", int'(s_ready), 1);
        end
        s_step(1, 1, 5, 0, 0);
        chk("R6 empty free list stalls", int'(s_ready), 0);
        s_step(0, 0, 0, 1, 0);
        s_step(1, 1, 5, 0, 0);
        chk("R6 still stalled while retiring", int'(s_ready), 0);
        chk("R8 small retire releases", int'(s_rold), 0);
        s_step(1, 1, 5, 0, 0);
        chk("R8 released register available", int'(s_ready), 1);
        chk("R8 released register allocated", int'(s_dphys), 0);
        s_step(0, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule